// File: doc/BRIEF.md
# Watchdog Reset Timer

This block is a memory-mapped countdown timer. When it runs out, it does not raise an interrupt. Instead it drives a one-cycle reset request to the processor core. Software controls it through a single read/write register on a simple slave port, made of a write strobe, write data and a read data output. Bit 31 of that register selects whether the timer reloads itself after expiry. The lower 31 bits hold the count.

Writing a value whose count field is zero stops the timer. Writing any nonzero count loads that count and starts the countdown. Software must rewrite the register before the count reaches zero, or the core is reset. In interval mode the timer reloads the last written count on every expiry, so it produces a periodic reset request.

Control is a two-state machine:

- ST_STOP is the idle state.
  - It moves to ST_RUN on a write with a nonzero count field.
  - It stays in ST_STOP on any other cycle.
- ST_RUN is the counting state.
  - It returns to ST_STOP on a write with a zero count field.
  - It returns to ST_STOP on a one-shot expiry.
  - It stays in ST_RUN while counting, on a reload after an interval expiry, and on a rewrite with a new nonzero count.

Top module: `wdog_reset_timer`

## Requirements
- R1: After reset, the count is 0, the timer is stopped, the mode bit reads 0 and `core_rst_req` is low.
- R2: A write whose bits 30:0 are zero stops the timer. On the next cycle the count is 0 and the mode bit is 0, whatever bit 31 held. No pulse follows until the next nonzero write.
- R3: A write whose bits 30:0 are nonzero loads that field as the count and as the reload value, and stores bit 31 as the mode bit (1 = interval, 0 = one-shot). Both are visible on the cycle after the write, whether the timer was stopped or running.
- R4: While running with no write, a count above 1 decreases by exactly one per clock.
- R5: When a running count steps from 1 to 0, `core_rst_req` is high for exactly the following cycle.
- R6: In one-shot mode, after expiry the count stays 0, the timer stays stopped, and no further pulse occurs until a write.
- R7: In interval mode, expiry reloads the count with the last loaded value in the same cycle as the pulse. Pulses then repeat every N cycles for a loaded count N, including every cycle when N is 1.
- R8: A write in the cycle where the count would expire takes priority: no pulse is produced and the written value takes effect.
- R9: `rd_data` always shows the mode bit in bit 31 and the current count in bits 30:0. `count` shows the same count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value: bit 31 mode, bits 30:0 count |
| rd_data | output | 32 | Register read value: bit 31 mode, bits 30:0 count |
| count | output | 31 | Current count |
| core_rst_req | output | 1 | One-cycle reset request to the core |

## Verification
The bench builds the block with its default 32-bit register. This allows a load of the largest count field, 2^31-1, which is then checked to decrement correctly. It also allows a zero count field paired with a set mode bit to be checked as a stop.

Random writes keep the count field small, so one-shot and interval expiries occur hundreds of times. These runs include reload values of 1 and writes landing exactly on the expiry cycle. Expiry from the maximum count lies far beyond the run length and is not reached.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [0:0] {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } wdt_state_e;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_zero,
    input  logic       at_one,
    input  logic       mode,
    output wdt_state_e state,
    output logic       do_load,
    output logic       do_stop,
    output logic       do_dec,
    output logic       do_reload,
    output logic       pulse_q
);
    wdt_state_e nxt;
    logic       fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= nxt;
    end

    // transitions and control outputs
    always_comb begin
        nxt       = state;
        do_load   = 1'b0;
        do_stop   = 1'b0;
        do_dec    = 1'b0;
        do_reload = 1'b0;
        fire      = 1'b0;
        unique case (state)
            ST_STOP: begin
                if (wr_en) begin
                    if (wr_zero) begin
                        do_stop = 1'b1;
                    end else begin
                        do_load = 1'b1;
                        nxt     = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (wr_en) begin
                    if (wr_zero) begin
                        do_stop = 1'b1;
                        nxt     = ST_STOP;
                    end else begin
                        do_load = 1'b1;
                    end
                end else if (at_one) begin
                    fire = 1'b1;
                    if (mode) begin
                        do_reload = 1'b1;
                    end else begin
                        do_stop = 1'b1;
                        nxt     = ST_STOP;
                    end
                end else begin
                    do_dec = 1'b1;
                end
            end
            default: nxt = ST_STOP;
        endcase
    end

    // registered reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire;
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wr_en) |=> (state == ST_STOP && !pulse_q));

    // R5
    pulse_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> ($past(state) == ST_RUN && !$past(wr_en)));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_stop,
    input  logic             do_dec,
    input  logic             do_reload,
    input  logic [CNT_W-1:0] wr_field,
    input  logic             wr_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             mode_q,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rel    <= '0;
            mode_q <= 1'b0;
        end else if (do_load) begin
            cnt    <= wr_field;
            rel    <= wr_field;
            mode_q <= wr_mode;
        end else if (do_stop) begin
            cnt    <= '0;
            mode_q <= 1'b0;
        end else if (do_reload) begin
            cnt    <= rel;
        end else if (do_dec) begin
            cnt    <= cnt - ONE;
        end
    end

    assign at_one = (cnt == ONE);

    // R7
    reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_reload |=> (cnt == $past(rel) && mode_q));
endmodule

// File: rtl/wdog_reset_timer.sv
module wdog_reset_timer
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-2:0] count,
    output logic              core_rst_req
);
    localparam int CNT_W = DATA_W - 1;

    wdt_state_e       state;
    logic             do_load, do_stop, do_dec, do_reload;
    logic             at_one, mode_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wr_field;
    logic             wr_zero;

    assign wr_field = wr_data[CNT_W-1:0];
    assign wr_zero  = (wr_field == '0);

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_zero   (wr_zero),
        .at_one    (at_one),
        .mode      (mode_q),
        .state     (state),
        .do_load   (do_load),
        .do_stop   (do_stop),
        .do_dec    (do_dec),
        .do_reload (do_reload),
        .pulse_q   (core_rst_req)
    );

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_load   (do_load),
        .do_stop   (do_stop),
        .do_dec    (do_dec),
        .do_reload (do_reload),
        .wr_field  (wr_field),
        .wr_mode   (wr_data[DATA_W-1]),
        .cnt       (cnt),
        .mode_q    (mode_q),
        .at_one    (at_one)
    );

    assign count   = cnt;
    assign rd_data = {mode_q, cnt};

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CNT_W-1:0] != '0) |=>
        (count == $past(wr_data[CNT_W-1:0]) && rd_data[DATA_W-1] == $past(wr_data[DATA_W-1])));

    // R2
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CNT_W-1:0] == '0) |=> (rd_data == '0 && state == ST_STOP));

    // R4
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wr_en && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

    // R5
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |-> ($past(count) == CNT_W'(1)));

    // R6
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_req && !rd_data[DATA_W-1]) |-> (count == '0 && state == ST_STOP));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !core_rst_req);
endmodule

// File: tb/test_wdog_reset_timer.sv
module test_wdog_reset_timer;
    localparam int DATA_W = 32;
    localparam int CNT_W  = DATA_W - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  count;
    logic              core_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    bit              m_run, m_mode, m_rst;
    logic [CNT_W-1:0] m_cnt, m_rel;

    always #10 clk = ~clk;

    wdog_reset_timer #(.DATA_W(DATA_W)) i_wdog_reset_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .count        (count),
        .core_rst_req (core_rst_req)
    );

    function automatic void model_step(input bit w, input logic [DATA_W-1:0] d);
        m_rst = 1'b0;
        if (w) begin
            if (d[CNT_W-1:0] == '0) begin
                m_run = 0; m_mode = 0; m_cnt = '0;
            end else begin
                m_run = 1; m_mode = d[DATA_W-1]; m_cnt = d[CNT_W-1:0]; m_rel = d[CNT_W-1:0];
            end
        end else if (m_run && m_cnt == CNT_W'(1)) begin
            m_rst = 1'b1;
            if (m_mode) m_cnt = m_rel;
            else begin m_cnt = '0; m_run = 0; end
        end else if (m_run) begin
            m_cnt = m_cnt - CNT_W'(1);
        end
    endfunction

    function automatic void check(input bit ok, input string tag, input logic [63:0] act,
                                  input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    task automatic compare(input string tag);
        check(rd_data == {m_mode, m_cnt}, tag, 64'(rd_data), 64'({m_mode, m_cnt}));
        check(count == m_cnt, {tag, " R9 count"}, 64'(count), 64'(m_cnt));
        check(core_rst_req == m_rst, {tag, " R5 pulse"}, 64'(core_rst_req), 64'(m_rst));
    endtask

    task automatic tick(input bit w, input logic [DATA_W-1:0] d, input string tag);
        wr_en = w;
        wr_data = d;
        @(posedge clk);
        model_step(w, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        m_run = 0; m_mode = 0; m_rst = 0; m_cnt = '0; m_rel = '0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        idle(3, "R1 after reset");

        // one-shot expiry and hold
        tick(1'b1, 32'h0000_0005, "R3 load");
        idle(5, "R4/R5 countdown");
        check(core_rst_req == 1'b1, "R5 pulse at expiry", 64'(core_rst_req), 64'd1);
        idle(6, "R6 stays stopped");
        check(rd_data == '0, "R6 count zero", 64'(rd_data), 64'd0);

        // interval expiry, period 3
        tick(1'b1, 32'h8000_0003, "R3 interval load");
        idle(10, "R7 interval");
        // interval with reload 1: pulse every cycle
        tick(1'b1, 32'h8000_0001, "R7 reload one");
        idle(4, "R7 every cycle");

        // zero-field write with mode bit stops
        tick(1'b1, 32'h8000_0000, "R2 stop mode set");
        check(rd_data == '0, "R2 mode cleared", 64'(rd_data), 64'd0);
        idle(4, "R2 no pulse");

        // write on the expiry cycle wins
        tick(1'b1, 32'h0000_0002, "R3 load");
        idle(1, "R4");
        tick(1'b1, 32'h0000_0007, "R8 write at expiry");
        check(core_rst_req == 1'b0, "R8 no pulse", 64'(core_rst_req), 64'd0);
        idle(3, "R8 new count");
        tick(1'b1, 32'h0000_0000, "R2 stop running");
        idle(3, "R2 stopped");

        // largest count field
        tick(1'b1, 32'h7fff_ffff, "R3 max load");
        idle(4, "R4 max decrement");
        tick(1'b1, 32'h0000_0000, "R2 stop");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                logic [DATA_W-1:0] d;
                d = '0;
                d[CNT_W-1:0] = CNT_W'($urandom_range(0, 12));
                d[DATA_W-1] = 1'($urandom_range(0, 1));
                tick(1'b1, d, "R3/R2 random write");
            end else begin
                tick(1'b0, '0, "R4/R5/R6/R7 random idle");
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule